// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block chooses the address the program counter of a 32-bit RISC core moves to after the instruction now in the execute stage. It is purely combinational. It receives the incremented PC and a sign-extended branch displacement. It also receives the ALU zero flag, the decoded controls for equal and not-equal branches, direct jump, register jump and link, the 26-bit target field of a jump word, and a register operand.

From these it forms three results: the next PC, a redirect flag, and the return address that the write-back stage stores. The redirect flag tells the PC register to leave the sequential path. The return address serves call-style jumps, both direct and through a register.

The unit merges four address sources: sequential, PC-relative branch, pseudo-direct jump and register jump. It picks between them in a fixed priority. The instruction memory, the PC register and any hazard or flush handling sit outside it.

Top module: `npc_unit`

## Requirements
- R1: With no branch taken and no jump control set, `next_pc` equals `pc_plus4` and `pc_redirect` is 0.
- R2: An equal-branch (`is_beq`) is taken when `zero_flag` is 1 and not taken when it is 0.
- R3: A not-equal-branch (`is_bne`) is taken when `zero_flag` is 0 and not taken when it is 1. If both branch controls are set, the branch is taken when either condition holds.
- R4: A taken branch gives `next_pc = pc_plus4 + (br_offset << 2)`, computed modulo 2^32.
- R5: A direct jump (`is_jump`) gives `next_pc = {pc_plus4[31:28], jfield[25:0], 2'b00}`.
- R6: A register jump (`is_jreg`) gives `next_pc = reg_target`, unmodified.
- R7: Priority is register jump, then direct jump, then taken branch, then `pc_plus4`.
- R8: `link_value` equals `pc_plus4` whenever `is_link` is 1 and is 0 otherwise, whatever source is chosen.
- R9: `pc_redirect` is 1 exactly when a non-sequential source is chosen, even if that target equals `pc_plus4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_plus4 | input | 32 | Address of the current instruction plus four |
| br_offset | input | 32 | Sign-extended branch displacement in words |
| zero_flag | input | 1 | ALU result was zero |
| is_beq | input | 1 | Branch if equal |
| is_bne | input | 1 | Branch if not equal |
| is_jump | input | 1 | Pseudo-direct jump |
| is_jreg | input | 1 | Jump to register value |
| is_link | input | 1 | Produce a return address |
| jfield | input | 26 | Target field of the jump word |
| reg_target | input | 32 | Register operand for register jumps |
| next_pc | output | 32 | Address the PC should load |
| pc_redirect | output | 1 | PC leaves the sequential path |
| link_value | output | 32 | Return address to write back |

## Verification
All three results are combinational, so each one is due in the same cycle the controls and operands are applied, with no register in between. The bench drives a stimulus one time unit after a rising edge and waits for the next rising edge. It samples one time unit after that edge, well clear of the edge and long after every path has settled. No result is checked later or earlier than the vector that caused it.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ      = 2'd0,
    SRC_BRANCH   = 2'd1,
    SRC_DIRECT   = 2'd2,
    SRC_REGISTER = 2'd3
  } npc_src_e;
endpackage

// File: rtl/npc_branch_eval.sv
module npc_branch_eval (
  input  logic zero_flag,
  input  logic is_beq,
  input  logic is_bne,
  output logic take_branch
);
  logic eq_hit;
  logic ne_hit;

  assign eq_hit      = is_beq & zero_flag;
  assign ne_hit      = is_bne & ~zero_flag;
  assign take_branch = eq_hit | ne_hit;

  always_comb begin
    // R2: equal-branch with zero set must be taken
    a_r2_beq_taken: assert (!(is_beq && zero_flag) || take_branch)
      else $error("R2 equal branch not taken");
    // R3: not-equal-branch with zero clear must be taken
    a_r3_bne_taken: assert (!(is_bne && !zero_flag) || take_branch)
      else $error("R3 not-equal branch not taken");
    // R1: no branch control means no branch
    a_r1_no_ctrl: assert (is_beq || is_bne || !take_branch)
      else $error("R1 branch taken without control");
  end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
  parameter int XLEN     = 32,
  parameter int JFIELD_W = 26,
  parameter int ALIGN    = 2
) (
  input  logic [XLEN-1:0]     pc_plus4,
  input  logic [XLEN-1:0]     br_offset,
  input  logic [JFIELD_W-1:0] jfield,
  output logic [XLEN-1:0]     branch_target,
  output logic [XLEN-1:0]     direct_target
);
  localparam int REGION_W = XLEN - JFIELD_W - ALIGN;

  function automatic logic [XLEN-1:0] fn_rel(input logic [XLEN-1:0] base,
                                             input logic [XLEN-1:0] words);
    return base + (words << ALIGN);
  endfunction

  function automatic logic [XLEN-1:0] fn_region(input logic [XLEN-1:0] base,
                                                input logic [JFIELD_W-1:0] fld);
    return {base[XLEN-1 -: REGION_W], fld, {ALIGN{1'b0}}};
  endfunction

  assign branch_target = fn_rel(pc_plus4, br_offset);
  assign direct_target = fn_region(pc_plus4, jfield);

  always_comb begin
    // R5: direct target stays word aligned and in the current region
    a_r5_region_kept: assert (direct_target[XLEN-1 -: REGION_W] == pc_plus4[XLEN-1 -: REGION_W]
                              && direct_target[ALIGN-1:0] == '0)
      else $error("R5 direct target malformed");
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_plus4,
  input  logic [XLEN-1:0] branch_target,
  input  logic [XLEN-1:0] direct_target,
  input  logic [XLEN-1:0] reg_target,
  input  logic            take_branch,
  input  logic            is_jump,
  input  logic            is_jreg,
  output npc_src_e        src,
  output logic [XLEN-1:0] next_pc,
  output logic            pc_redirect
);
  always_comb begin
    if (is_jreg)          src = SRC_REGISTER;
    else if (is_jump)     src = SRC_DIRECT;
    else if (take_branch) src = SRC_BRANCH;
    else                  src = SRC_SEQ;
  end

  always_comb begin
    case (src)
      SRC_REGISTER: next_pc = reg_target;
      SRC_DIRECT:   next_pc = direct_target;
      SRC_BRANCH:   next_pc = branch_target;
      default:      next_pc = pc_plus4;
    endcase
  end

  assign pc_redirect = (src != SRC_SEQ);

  always_comb begin
    // R7: register jump overrides every other source
    a_r7_reg_first: assert (!is_jreg || next_pc == reg_target)
      else $error("R7 register jump lost priority");
    // R7: direct jump overrides a branch
    a_r7_direct_second: assert (is_jreg || !is_jump || next_pc == direct_target)
      else $error("R7 direct jump lost priority");
    // R9: no redirect means the sequential address
    a_r9_seq_when_idle: assert (pc_redirect || next_pc == pc_plus4)
      else $error("R9 idle path not sequential");
    // R9: any jump control forces a redirect
    a_r9_jump_redirects: assert (!(is_jump || is_jreg) || pc_redirect)
      else $error("R9 jump without redirect");
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int JFIELD_W = 26,
  parameter int ALIGN    = 2
) (
  input  logic [XLEN-1:0]     pc_plus4,
  input  logic [XLEN-1:0]     br_offset,
  input  logic                zero_flag,
  input  logic                is_beq,
  input  logic                is_bne,
  input  logic                is_jump,
  input  logic                is_jreg,
  input  logic                is_link,
  input  logic [JFIELD_W-1:0] jfield,
  input  logic [XLEN-1:0]     reg_target,
  output logic [XLEN-1:0]     next_pc,
  output logic                pc_redirect,
  output logic [XLEN-1:0]     link_value
);
  logic            take_branch;
  logic [XLEN-1:0] branch_target;
  logic [XLEN-1:0] direct_target;
  npc_src_e        src;

  npc_branch_eval u_eval (
    .zero_flag   (zero_flag),
    .is_beq      (is_beq),
    .is_bne      (is_bne),
    .take_branch (take_branch)
  );

  npc_target_gen #(.XLEN(XLEN), .JFIELD_W(JFIELD_W), .ALIGN(ALIGN)) u_tgt (
    .pc_plus4      (pc_plus4),
    .br_offset     (br_offset),
    .jfield        (jfield),
    .branch_target (branch_target),
    .direct_target (direct_target)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .pc_plus4      (pc_plus4),
    .branch_target (branch_target),
    .direct_target (direct_target),
    .reg_target    (reg_target),
    .take_branch   (take_branch),
    .is_jump       (is_jump),
    .is_jreg       (is_jreg),
    .src           (src),
    .next_pc       (next_pc),
    .pc_redirect   (pc_redirect)
  );

  assign link_value = is_link ? pc_plus4 : '0;

  always_comb begin
    // R8: return address is the sequential address whenever linking
    a_r8_link_seq: assert (!is_link || link_value == pc_plus4)
      else $error("R8 link value wrong");
    a_r8_link_quiet: assert (is_link || link_value == '0)
      else $error("R8 link value not quiet");
    // R4: a branch selection lands on the branch target
    a_r4_branch_used: assert (src != SRC_BRANCH || next_pc == branch_target)
      else $error("R4 branch target not used");
  end
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  typedef struct packed {
    logic [31:0] pc4;
    logic [31:0] off;
    logic        z;
    logic        beq;
    logic        bne;
    logic        jmp;
    logic        jr;
    logic        lk;
    logic [25:0] jf;
    logic [31:0] rv;
    logic [31:0] exp_pc;
    logic        exp_rd;
    logic [31:0] exp_link;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    // R1 sequential
    '{32'h0040_0004, 32'h10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0, 32'h0, 32'h0040_0004, 1'b0, 32'h0},
    // R2 equal taken, R4 target
    '{32'h0040_0004, 32'h10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0, 32'h0, 32'h0040_0044, 1'b1, 32'h0},
    // R2 equal not taken
    '{32'h0040_0004, 32'h10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0, 32'h0, 32'h0040_0004, 1'b0, 32'h0},
    // R3 not-equal taken, R4 negative offset
    '{32'h0040_0004, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0, 32'h0, 32'h003F_FFFC, 1'b1, 32'h0},
    // R3 not-equal not taken
    '{32'h0040_0004, 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0, 32'h0, 32'h0040_0004, 1'b0, 32'h0},
    // R5 direct jump, full field
    '{32'hA000_0010, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 26'h3FF_FFFF, 32'h0, 32'hAFFF_FFFC, 1'b1, 32'h0},
    // R5 R8 direct jump with link
    '{32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 26'h000_0001, 32'h0, 32'h1000_0004, 1'b1, 32'h1234_5678},
    // R6 R7 register jump beats jump and taken branch
    '{32'h0040_0004, 32'h10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 26'h123, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 32'h0},
    // R6 R8 register jump with link
    '{32'h0000_1000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 26'h0, 32'h0000_2000, 32'h0000_2000, 1'b1, 32'h0000_1000},
    // R7 direct jump beats taken branch
    '{32'h0040_0004, 32'h10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 26'h010_0000, 32'h0, 32'h0040_0000, 1'b1, 32'h0},
    // R4 wrap-around
    '{32'hFFFF_FFFC, 32'h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 26'h0, 32'h0, 32'h0000_0000, 1'b1, 32'h0},
    // R3 both branch controls, zero clear
    '{32'h0000_0100, 32'h4, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 26'h0, 32'h0, 32'h0000_0110, 1'b1, 32'h0},
    // R8 link alone does not redirect
    '{32'h0000_0200, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 26'h0, 32'h0, 32'h0000_0200, 1'b0, 32'h0000_0200}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] pc_plus4, br_offset, reg_target;
  logic        zero_flag, is_beq, is_bne, is_jump, is_jreg, is_link;
  logic [25:0] jfield;
  logic [31:0] next_pc, link_value;
  logic        pc_redirect;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  npc_unit u_npc_unit (
    .pc_plus4    (pc_plus4),
    .br_offset   (br_offset),
    .zero_flag   (zero_flag),
    .is_beq      (is_beq),
    .is_bne      (is_bne),
    .is_jump     (is_jump),
    .is_jreg     (is_jreg),
    .is_link     (is_link),
    .jfield      (jfield),
    .reg_target  (reg_target),
    .next_pc     (next_pc),
    .pc_redirect (pc_redirect),
    .link_value  (link_value)
  );

  task automatic apply(input vec_t v);
    pc_plus4 = v.pc4; br_offset = v.off; zero_flag = v.z;
    is_beq = v.beq; is_bne = v.bne; is_jump = v.jmp;
    is_jreg = v.jr; is_link = v.lk; jfield = v.jf; reg_target = v.rv;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input string tag, input vec_t v);
    @(posedge clk); #1;
    apply(v);
    @(posedge clk); #1;
    check({tag, " next_pc"}, next_pc, v.exp_pc);
    check({tag, " redirect"}, {31'b0, pc_redirect}, {31'b0, v.exp_rd});
    check({tag, " link"}, link_value, v.exp_link);
  endtask

  initial begin
    vec_t d;
    // R1 idle state: all controls low, zero inputs
    d = '0;
    run_vec("R1 idle", d);
    for (int i = 0; i < NV; i++) begin
      run_vec($sformatf("vector %0d", i), VEC[i]);
    end
    // R9 register jump to the sequential address still redirects
    d = '0; d.pc4 = 32'h0000_0800; d.rv = 32'h0000_0800; d.jr = 1'b1;
    d.exp_pc = 32'h0000_0800; d.exp_rd = 1'b1;
    run_vec("R9 jreg to seq addr", d);
    // R9 zero-offset branch still redirects
    d = '0; d.pc4 = 32'h0000_0900; d.beq = 1'b1; d.z = 1'b1;
    d.exp_pc = 32'h0000_0900; d.exp_rd = 1'b1;
    run_vec("R9 zero offset branch", d);
    // R1 jump field and register ignored when no jump control is set
    d = '0; d.pc4 = 32'h0000_0A00; d.jf = 26'h3FF_FFFF; d.rv = 32'hFFFF_FFFF;
    d.exp_pc = 32'h0000_0A00;
    run_vec("R1 fields ignored", d);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule